// File: doc/BRIEF.md
# Variable-Page TLB Lookup Array

This block is a fully associative translation buffer. Each entry pairs a tag with a data half. The tag holds an effective page number, a page-size code, a valid flag, an endian flag, a user flag and an owner ID. The data half holds a real page number, a zone selector, execute and write enables, and four storage-attribute bits. A lookup presents a 32-bit effective address together with the current process ID. One cycle later the block returns hit, the matching slot, the translated real address and the slot's permission and attribute bits.

The page size varies per entry, from 1 KiB to 16 MiB in steps of four. Address bits that fall inside the page pass straight through to the real address. A write port loads either half of any slot, and the owner ID comes from the process-ID input. A read port returns either half. A separate search port reports which slot, if any, would match an address. Fault decisions, zone checks and refill policy belong to the surrounding logic.

Top module: `vpt_tlb`

## Requirements
- R1: Reset clears every valid flag. A lookup or search then misses until a tag with its valid flag set has been written.
- R2: A tag write stores wr_word[31:10] as the page number, [9:7] as the size code, [6] as valid, [5] as endian and [4] as user. The owner ID is taken from pid_i in the same cycle.
- R3: A data write stores wr_word[31:10] as the real page number, [9:6] as the zone selector, [5] as execute, [4] as write, and [3:0] as the W, I, M and G attributes from bit 3 down to bit 0.
- R4: A slot matches only when all three conditions hold: its valid flag is set, its page number equals lk_ea[31:10] on the bits its size keeps, and its owner ID equals the process ID.
- R5: Size code s selects a page of 1 KiB times 4 to the power s. The compare ignores the 2*s lowest page-number bits. Real address bits below 10+2*s are copied from the effective address, and the bits above come from the real page number.
- R6: A stored owner ID of zero matches every process ID. A nonzero process ID never matches a slot owned by a different nonzero ID. A process ID of zero matches only slots owned by zero.
- R7: Lookup outputs change on the clock edge after lk_valid is sampled. A write is seen by lookups sampled on the next edge. A lookup sampled on the same edge as a write sees the old contents.
- R8: On a miss, lk_idx, lk_ra and every permission and attribute output are zero.
- R9: While lk_valid is low, every lookup output holds its last value.
- R10: When several slots match, the lowest-numbered one is reported. The block does not stall in this case.
- R11: A read sampled with rd_en returns on the next edge. For a tag read (rd_half=0), rd_word is packed in the R2 layout, and bits [3:0] are zero. For a data read (rd_half=1), rd_word is packed in the R3 layout. rd_tid returns the owner ID on a tag read and zero on a data read.
- R12: A search sampled with sx_valid applies the R4 rule to sx_ea and pid_i. It reports sx_hit and sx_idx on the next edge, with sx_idx zero on a miss, and agrees with a lookup of the same address.
- R13: On a hit, the zone selector, execute, write, attributes, endian and user outputs equal the fields stored in the matching slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pid_i | input | 8 | Current process ID for lookup, search and tag write |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IW | Matching slot |
| lk_ra | output | 32 | Translated real address |
| lk_zsel | output | 4 | Zone selector of the slot |
| lk_ex | output | 1 | Execute enable |
| lk_wr | output | 1 | Write enable |
| lk_attr | output | 4 | W, I, M, G attributes (bit 3 down to 0) |
| lk_endian | output | 1 | Endian flag |
| lk_user | output | 1 | User flag |
| wr_en | input | 1 | Write strobe |
| wr_half | input | 1 | 0 tag, 1 data |
| wr_idx | input | IW | Slot written |
| wr_word | input | 32 | Packed write word |
| rd_en | input | 1 | Read strobe |
| rd_half | input | 1 | 0 tag, 1 data |
| rd_idx | input | IW | Slot read |
| rd_word | output | 32 | Packed read word |
| rd_tid | output | 8 | Owner ID returned by a tag read |
| sx_valid | input | 1 | Search request |
| sx_ea | input | 32 | Search effective address |
| sx_hit | output | 1 | Search hit |
| sx_idx | output | IW | Slot found by the search |

## Verification
The bench builds the array with ENTRIES=8 and a 3-bit index. With that size, every slot can be given a purpose at once. The fill includes two ID-distinguished twins, two overlapping entries that test the lowest-slot priority, an entry whose tag is invalid, and a spare slot. The spare slot is rewritten through all eight size codes, so every page boundary is probed just inside and just outside. The same small array also keeps the same-edge write and lookup case and the mid-run reset easy to set up.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  parameter int EA_W   = 32;
  parameter int OFF_W  = 10;
  parameter int EPN_W  = EA_W - OFF_W;
  parameter int PID_W  = 8;
  parameter int SZ_W   = 3;
  parameter int ZSEL_W = 4;
  parameter int ATTR_W = 4;
  parameter int WORD_W = 32;

  // tag word bit positions (behaviour: read word layout)
  localparam int T_SZ_LO = OFF_W - SZ_W;
  localparam int T_V_BIT = T_SZ_LO - 1;
  localparam int T_E_BIT = T_V_BIT - 1;
  localparam int T_U_BIT = T_E_BIT - 1;

  typedef enum logic {HALF_TAG = 1'b0, HALF_DATA = 1'b1} half_e;

  typedef struct packed {
    logic [EPN_W-1:0] epn;
    logic [SZ_W-1:0]  size;
    logic             endian;
    logic             user;
    logic [PID_W-1:0] tid;
  } tag_t;

  typedef struct packed {
    logic [EPN_W-1:0]  rpn;
    logic [ZSEL_W-1:0] zsel;
    logic              ex;
    logic              wr;
    logic [ATTR_W-1:0] attr;
  } data_t;

  // keeps the upper page-number bits that a page of this size compares
  function automatic logic [EPN_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    page_mask = {EPN_W{1'b1}} << (2 * sz);
  endfunction
endpackage

// File: rtl/vpt_store.sv
module vpt_store
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_half,
  input  logic [IW-1:0]           wr_idx,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic [PID_W-1:0]        wr_pid,
  output tag_t  [ENTRIES-1:0]     tag_q,
  output data_t [ENTRIES-1:0]     dat_q,
  output logic  [ENTRIES-1:0]     valid_q
);
  logic        tag_we, dat_we;
  tag_t        tag_wd;
  data_t       dat_wd;
  logic [ENTRIES-1:0] valid_d;

  always_comb begin
    tag_we = wr_en && (wr_half == HALF_TAG);
    dat_we = wr_en && (wr_half == HALF_DATA);
    tag_wd.epn    = wr_word[WORD_W-1:OFF_W];
    tag_wd.size   = wr_word[OFF_W-1:T_SZ_LO];
    tag_wd.endian = wr_word[T_E_BIT];
    tag_wd.user   = wr_word[T_U_BIT];
    tag_wd.tid    = wr_pid;
    dat_wd        = data_t'(wr_word);
    valid_d       = valid_q;
    if (tag_we) valid_d[wr_idx] = wr_word[T_V_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[wr_idx] <= tag_wd;
    if (dat_we) dat_q[wr_idx] <= dat_wd;
  end
endmodule

// File: rtl/vpt_cam.sv
module vpt_cam
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  tag_t [ENTRIES-1:0] tag_q,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [EA_W-1:0]    ea,
  input  logic [PID_W-1:0]   pid,
  output logic [ENTRIES-1:0] match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic [EPN_W-1:0] keep;
    logic             pg_eq, id_eq;
    always_comb begin
      keep  = page_mask(tag_q[g].size);
      pg_eq = ((ea[EA_W-1:OFF_W] ^ tag_q[g].epn) & keep) == '0;
      id_eq = (tag_q[g].tid == '0) || (tag_q[g].tid == pid);
      match[g] = valid_q[g] && pg_eq && id_eq;
    end
  end
endmodule

// File: rtl/vpt_penc.sv
module vpt_penc #(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IW-1:0]      idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              lk_valid,
  input  logic [EA_W-1:0]   lk_ea,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_idx,
  output logic [EA_W-1:0]   lk_ra,
  output logic [ZSEL_W-1:0] lk_zsel,
  output logic              lk_ex,
  output logic              lk_wr,
  output logic [ATTR_W-1:0] lk_attr,
  output logic              lk_endian,
  output logic              lk_user,
  input  logic              wr_en,
  input  logic              wr_half,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic              rd_half,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [PID_W-1:0]  rd_tid,
  input  logic              sx_valid,
  input  logic [EA_W-1:0]   sx_ea,
  output logic              sx_hit,
  output logic [IW-1:0]     sx_idx
);
  tag_t  [ENTRIES-1:0] tag_q;
  data_t [ENTRIES-1:0] dat_q;
  logic  [ENTRIES-1:0] valid_q;
  logic  [ENTRIES-1:0] lk_match, sx_match;
  logic                lk_any, sx_any;
  logic  [IW-1:0]      lk_sel, sx_sel;

  vpt_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_half(wr_half),
    .wr_idx(wr_idx), .wr_word(wr_word), .wr_pid(pid_i),
    .tag_q(tag_q), .dat_q(dat_q), .valid_q(valid_q)
  );

  vpt_cam #(.ENTRIES(ENTRIES)) u_cam_lk (
    .tag_q(tag_q), .valid_q(valid_q), .ea(lk_ea), .pid(pid_i), .match(lk_match)
  );
  vpt_cam #(.ENTRIES(ENTRIES)) u_cam_sx (
    .tag_q(tag_q), .valid_q(valid_q), .ea(sx_ea), .pid(pid_i), .match(sx_match)
  );

  vpt_penc #(.ENTRIES(ENTRIES)) u_penc_lk (.req(lk_match), .any(lk_any), .idx(lk_sel));
  vpt_penc #(.ENTRIES(ENTRIES)) u_penc_sx (.req(sx_match), .any(sx_any), .idx(sx_sel));

  // ---------------- lookup next state ----------------
  tag_t             sel_tag;
  data_t            sel_dat;
  logic [EPN_W-1:0] keep;
  logic             lk_hit_d;
  logic [IW-1:0]    lk_idx_d;
  logic [EA_W-1:0]  lk_ra_d;
  data_t            lk_dat_d;
  logic             lk_e_d, lk_u_d;

  always_comb begin
    sel_tag  = tag_q[lk_sel];
    sel_dat  = dat_q[lk_sel];
    keep     = page_mask(sel_tag.size);
    lk_hit_d = lk_any;
    lk_idx_d = '0;
    lk_ra_d  = '0;
    lk_dat_d = '0;
    lk_e_d   = 1'b0;
    lk_u_d   = 1'b0;
    if (lk_any) begin
      lk_idx_d = lk_sel;
      lk_ra_d  = {(sel_dat.rpn & keep) | (lk_ea[EA_W-1:OFF_W] & ~keep),
                  lk_ea[OFF_W-1:0]};
      lk_dat_d = sel_dat;
      lk_e_d   = sel_tag.endian;
      lk_u_d   = sel_tag.user;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit    <= 1'b0;
      lk_idx    <= '0;
      lk_ra     <= '0;
      lk_zsel   <= '0;
      lk_ex     <= 1'b0;
      lk_wr     <= 1'b0;
      lk_attr   <= '0;
      lk_endian <= 1'b0;
      lk_user   <= 1'b0;
    end else if (lk_valid) begin
      lk_hit    <= lk_hit_d;
      lk_idx    <= lk_idx_d;
      lk_ra     <= lk_ra_d;
      lk_zsel   <= lk_dat_d.zsel;
      lk_ex     <= lk_dat_d.ex;
      lk_wr     <= lk_dat_d.wr;
      lk_attr   <= lk_dat_d.attr;
      lk_endian <= lk_e_d;
      lk_user   <= lk_u_d;
    end
  end

  // ---------------- read next state ----------------
  tag_t              rd_tag;
  logic [WORD_W-1:0] rd_word_d;
  logic [PID_W-1:0]  rd_tid_d;

  always_comb begin
    rd_tag = tag_q[rd_idx];
    if (rd_half == HALF_DATA) begin
      rd_word_d = WORD_W'(dat_q[rd_idx]);
      rd_tid_d  = '0;
    end else begin
      rd_word_d = {rd_tag.epn, rd_tag.size, valid_q[rd_idx],
                   rd_tag.endian, rd_tag.user, {T_U_BIT{1'b0}}};
      rd_tid_d  = rd_tag.tid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
      rd_tid  <= '0;
    end else if (rd_en) begin
      rd_word <= rd_word_d;
      rd_tid  <= rd_tid_d;
    end
  end

  // ---------------- search next state ----------------
  logic [IW-1:0] sx_idx_d;
  always_comb sx_idx_d = sx_any ? sx_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sx_hit <= 1'b0;
      sx_idx <= '0;
    end else if (sx_valid) begin
      sx_hit <= sx_any;
      sx_idx <= sx_idx_d;
    end
  end
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [EA_W-1:0]   lk_ea,
  input logic              lk_hit,
  input logic [IW-1:0]     lk_idx,
  input logic [EA_W-1:0]   lk_ra,
  input logic [ZSEL_W-1:0] lk_zsel,
  input logic              lk_ex,
  input logic              lk_wr,
  input logic [ATTR_W-1:0] lk_attr,
  input logic              lk_endian,
  input logic              lk_user,
  input logic              wr_en,
  input logic              wr_half,
  input logic [WORD_W-1:0] wr_word,
  input logic              rd_en,
  input logic              rd_half,
  input logic [PID_W-1:0]  rd_tid,
  input logic              sx_valid,
  input logic [EA_W-1:0]   sx_ea,
  input logic              sx_hit,
  input logic [IW-1:0]     sx_idx
);
  logic seen_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_valid <= 1'b0;
    else if (wr_en && wr_half == HALF_TAG && wr_word[T_V_BIT]) seen_valid <= 1'b1;
  end

  a_r1_no_hit_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> seen_valid);

  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ra == '0 && lk_idx == '0 && lk_zsel == '0 && !lk_ex &&
                 !lk_wr && lk_attr == '0 && !lk_endian && !lk_user));

  a_r5_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && $past(lk_valid)) |-> lk_ra[OFF_W-1:0] == $past(lk_ea[OFF_W-1:0]));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid) |-> ($stable(lk_hit) && $stable(lk_ra) && $stable(lk_idx)));

  a_r12_search_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_valid && sx_valid && lk_ea == sx_ea) |->
      (lk_hit == sx_hit && lk_idx == sx_idx));

  a_r11_data_tid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && rd_half == HALF_DATA) |-> rd_tid == '0);
endmodule

bind vpt_tlb vpt_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/vpt_tlb_bench.sv
`timescale 1ns/1ps
module vpt_tlb_bench;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [7:0] pid_i;
  logic lk_valid; logic [31:0] lk_ea;
  logic lk_hit; logic [IW-1:0] lk_idx; logic [31:0] lk_ra;
  logic [3:0] lk_zsel; logic lk_ex, lk_wr; logic [3:0] lk_attr; logic lk_endian, lk_user;
  logic wr_en, wr_half; logic [IW-1:0] wr_idx; logic [31:0] wr_word;
  logic rd_en, rd_half; logic [IW-1:0] rd_idx; logic [31:0] rd_word; logic [7:0] rd_tid;
  logic sx_valid; logic [31:0] sx_ea; logic sx_hit; logic [IW-1:0] sx_idx;

  vpt_tlb #(.ENTRIES(N)) u_vpt_tlb (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tagw(input logic [21:0] epn, input logic [2:0] sz,
                                       input logic v, input logic e, input logic u);
    return {epn, sz, v, e, u, 4'b0};
  endfunction
  function automatic logic [31:0] datw(input logic [21:0] rpn, input logic [3:0] zs,
                                       input logic ex, input logic wr, input logic [3:0] at);
    return {rpn, zs, ex, wr, at};
  endfunction

  task automatic wr(input logic half, input int idx, input logic [31:0] w, input logic [7:0] pid);
    wr_en = 1; wr_half = half; wr_idx = IW'(idx); wr_word = w; pid_i = pid;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] ea, input logic [7:0] pid);
    lk_valid = 1; lk_ea = ea; sx_valid = 1; sx_ea = ea; pid_i = pid;
    @(negedge clk);
    lk_valid = 0; sx_valid = 0;
  endtask

  task automatic rd(input logic half, input int idx);
    rd_en = 1; rd_half = half; rd_idx = IW'(idx);
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic [11:0] attrs();
    return {lk_zsel, lk_ex, lk_wr, lk_attr, lk_endian, lk_user};
  endfunction

  typedef struct packed {
    logic [31:0] ea; logic [7:0] pid; logic hit; logic [2:0] idx;
    logic [31:0] ra; logic [11:0] at;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_12A4, 8'h05, 1'b1, 3'd0, 32'h0004_02A4, 12'h3AA},  // R4 id 5
    '{32'h0000_12A4, 8'h07, 1'b1, 3'd3, 32'h0008_02A4, 12'h204},  // R4 twin, id 7
    '{32'h0000_12A4, 8'h06, 1'b0, 3'd0, 32'h0,         12'h000},  // R4 id mismatch
    '{32'h0004_3FFC, 8'h33, 1'b1, 3'd1, 32'h02AF_3FFC, 12'hF55},  // R6 wildcard, R5 16K
    '{32'h0004_4000, 8'h33, 1'b0, 3'd0, 32'h0,         12'h000},  // R5 above page
    '{32'h0003_FFFC, 8'h33, 1'b0, 3'd0, 32'h0,         12'h000},  // R5 below page
    '{32'hFF12_3456, 8'h09, 1'b1, 3'd2, 32'h0112_3456, 12'h0FC},  // R5 16M
    '{32'hFEFF_FFFF, 8'h09, 1'b0, 3'd0, 32'h0,         12'h000},  // R5 below 16M
    '{32'hFF12_3456, 8'h08, 1'b0, 3'd0, 32'h0,         12'h000},  // R6 other id
    '{32'h0020_0ABC, 8'h01, 1'b1, 3'd4, 32'h0014_0ABC, 12'h000},  // R10 lowest of 4,5
    '{32'h0040_0000, 8'h00, 1'b0, 3'd0, 32'h0,         12'h000},  // R4 invalid tag
    '{32'h0000_12A4, 8'h00, 1'b0, 3'd0, 32'h0,         12'h000}   // R6 pid 0 vs id 5
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pid_i = 0; lk_valid = 0; lk_ea = 0; wr_en = 0; wr_half = 0;
    wr_idx = 0; wr_word = 0; rd_en = 0; rd_half = 0; rd_idx = 0; sx_valid = 0; sx_ea = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state, nothing written
    chk("R1", "reset hit", lk_hit, 0);
    chk("R1", "reset rd_word", rd_word, 0);
    look(32'h0000_12A4, 8'h05);
    chk("R1", "empty lookup hit", lk_hit, 0);
    chk("R1", "empty search hit", sx_hit, 0);

    // fill (R2, R3)
    wr(1, 0, datw(22'h00100, 4'h3, 1, 0, 4'b1010), 0);
    wr(0, 0, tagw(22'h00004, 3'd0, 1, 1, 0), 8'h05);
    wr(1, 1, datw(22'h0ABC3, 4'hF, 0, 1, 4'b0101), 0);
    wr(0, 1, tagw(22'h00100, 3'd2, 1, 0, 1), 8'h00);
    wr(1, 2, datw(22'h04000, 4'h0, 1, 1, 4'b1111), 0);
    wr(0, 2, tagw(22'h3FC000, 3'd7, 1, 0, 0), 8'h09);
    wr(1, 3, datw(22'h00200, 4'h2, 0, 0, 4'b0001), 0);
    wr(0, 3, tagw(22'h00004, 3'd0, 1, 0, 0), 8'h07);
    wr(1, 4, datw(22'h00500, 4'h0, 0, 0, 4'b0000), 0);
    wr(0, 4, tagw(22'h00800, 3'd1, 1, 0, 0), 8'h00);
    wr(1, 5, datw(22'h00600, 4'h1, 1, 1, 4'b1111), 0);
    wr(0, 5, tagw(22'h00800, 3'd1, 1, 0, 0), 8'h00);
    wr(1, 6, datw(22'h00700, 4'h1, 1, 1, 4'b1111), 0);
    wr(0, 6, tagw(22'h01000, 3'd0, 0, 0, 0), 8'h00);

    for (int k = 0; k < NV; k++) begin
      look(VEC[k].ea, VEC[k].pid);
      chk("R4",  $sformatf("v%0d hit", k), lk_hit, VEC[k].hit);
      chk("R10", $sformatf("v%0d idx", k), lk_idx, VEC[k].idx);
      chk("R5",  $sformatf("v%0d ra", k), lk_ra, VEC[k].ra);
      chk("R13", $sformatf("v%0d attrs", k), attrs(), VEC[k].at);
      chk("R12", $sformatf("v%0d search", k), {sx_hit, sx_idx}, {VEC[k].hit, VEC[k].idx});
    end

    // R9: idle lookup holds outputs
    look(32'hFF12_3456, 8'h09);
    lk_ea = 32'h0000_0000; pid_i = 8'h00;
    @(negedge clk);
    chk("R9", "hold hit", lk_hit, 1);
    chk("R9", "hold ra", lk_ra, 32'h0112_3456);
    chk("R9", "hold idx", lk_idx, 2);

    // R11: reads
    rd(0, 0);
    chk("R11", "tag word", rd_word, tagw(22'h00004, 3'd0, 1, 1, 0));
    chk("R2",  "tag id from pid", rd_tid, 8'h05);
    rd(1, 1);
    chk("R3",  "data word", rd_word, datw(22'h0ABC3, 4'hF, 0, 1, 4'b0101));
    chk("R11", "data tid", rd_tid, 0);

    // R7: same-edge write sees old, next sees new
    wr(1, 7, datw(22'h080000, 4'h0, 0, 0, 4'b0000), 0);
    wr_en = 1; wr_half = 0; wr_idx = 3'd7; wr_word = tagw(22'h02000, 3'd0, 1, 0, 0);
    pid_i = 8'h00; lk_valid = 1; lk_ea = 32'h0080_0010; sx_valid = 0;
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
    chk("R7", "same-edge lookup", lk_hit, 0);
    look(32'h0080_0010, 8'h44);
    chk("R7", "next-edge lookup", {lk_hit, lk_idx}, {1'b1, 3'd7});
    chk("R7", "next-edge ra", lk_ra, 32'h2000_0010);

    // R5: every size code, just inside and just outside
    for (int s = 0; s < 8; s++) begin
      logic [31:0] sz;
      sz = 32'd1024 << (2 * s);
      wr(0, 7, tagw(22'h100000, 3'(s), 1, 0, 0), 8'h00);
      look(32'h4000_0000 + sz - 1, 8'h44);
      chk("R5", $sformatf("size %0d last byte", s), {lk_hit, lk_idx}, {1'b1, 3'd7});
      chk("R5", $sformatf("size %0d ra", s), lk_ra, 32'h2000_0000 + sz - 1);
      look(32'h4000_0000 + sz, 8'h44);
      chk("R5", $sformatf("size %0d past end", s), lk_hit, 0);
      look(32'h3FFF_FFFF, 8'h44);
      chk("R5", $sformatf("size %0d before start", s), lk_hit, 0);
    end

    // R4: clearing valid removes entry
    wr(0, 0, tagw(22'h00004, 3'd0, 0, 1, 0), 8'h05);
    look(32'h0000_12A4, 8'h05);
    chk("R4", "invalidated miss", lk_hit, 0);
    chk("R8", "miss ra zero", lk_ra, 0);
    chk("R12", "invalidated search", sx_hit, 0);

    // R1: reset mid-run clears valid flags
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    look(32'h0004_3FFC, 8'h33);
    chk("R1", "after reset miss", lk_hit, 0);
    chk("R8", "after reset attrs", attrs(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule